// File: doc/BRIEF.md
# Shadow Memory Store/Recall Sequencer

This block controls a volatile memory array that has a nonvolatile shadow copy behind it. It watches two digitised supply flags: one that says the supply is above the switch threshold, and one that says the supply has sunk below the deeper reset threshold. From these flags it decides when to copy the array into the shadow (store) and when to copy the shadow back into the array (recall). It also gates host writes and tracks whether the array holds data that the shadow does not yet have.

When the supply droops, a dirty array is saved. The store begins after a short grace window that lets a host cycle already under way finish. A clean array is not saved. A recall is owed only after the supply has really fallen below the reset level, and after reset. It runs as soon as the supply is good again. Software may also ask for a recall while the sequencer is idle. Every operation is timed by a cycle counter, so the durations are parameters: `GRACE_CYC`, `STORE_CYC` and `RECALL_CYC`.

Top module: `nvshadow_seq`

## Requirements
- R1: While reset is held, `busy`, `store_go` and `recall_go` are 0 and `wr_inhibit` is 1. Reset leaves a recall owed, so the first cycle sampled with `sup_ok`=1 and `sup_dead`=0 starts a recall.
- R2: `wr_inhibit` is 0 only when the sequencer is idle, not busy, and `sup_ok`=1. A `host_wr` sampled while `wr_inhibit`=1 has no effect on the dirty state.
- R3: `sup_ok` may be sampled low while idle with at least one accepted write since the last completed store or recall. In that case `store_go` pulses for one cycle exactly `GRACE_CYC`+1 cycles after that sampling edge, at the start of the store.
- R4: A drop of `sup_ok` while idle with a clean array produces no `store_go`, and `busy` stays 0.
- R5: A store keeps `busy` high for exactly `STORE_CYC` cycles and runs to the end regardless of the supply flags. `store_go` and `recall_go` are never high together.
- R6: A recall is owed only if `sup_dead`=1 is sampled, after reset, or after an accepted software recall. A brownout that never reaches `sup_dead` produces no recall when `sup_ok` returns. This holds whether or not a store was made.
- R7: The first cycle sampled with `sup_ok`=1 (and `sup_dead`=0) while a recall is owed is followed, on the next cycle, by a one-cycle `recall_go`. `busy` then stays high for exactly `RECALL_CYC` cycles. This includes the case where a store ran during the deep brownout.
- R8: A completed store or recall makes the array clean, so a later supply drop without new writes makes no store.
- R9: `sw_recall` starts a recall only when sampled while idle with `sup_ok`=1. It is ignored while busy or while the supply is low.
- R10: If `sup_ok`=0 or `sup_dead`=1 is sampled during a recall, the recall is abandoned and `busy` falls on the next cycle. The recall stays owed and restarts, at full length, on the next good supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_ok | input | 1 | Supply above the switch threshold |
| sup_dead | input | 1 | Supply below the reset threshold |
| host_wr | input | 1 | Host write cycle to the volatile array |
| sw_recall | input | 1 | Software request for a recall |
| wr_inhibit | output | 1 | Blocks writes into the volatile array |
| busy | output | 1 | A store or recall is running |
| store_go | output | 1 | One-cycle strobe at the start of a store |
| recall_go | output | 1 | One-cycle strobe at the start of a recall |

## Verification
The hardest situation to reach is a recall abandoned part-way through and then restarted. The supply has to collapse below the reset level inside the recall window, after an earlier deep brownout has already made the recall owed. The stimulus gets there in a directed sequence. It forces a deep brownout, raises the supply, waits a few cycles into the recall, and collapses the supply again. It then measures the full busy length of the restarted recall. Random rounds then mix writes, shallow and deep brownouts, and dwell times, and a bench model predicts each store and recall decision.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GRACE  = 3'd1,
    ST_STORE  = 3'd2,
    ST_DOWN   = 3'd3,
    ST_RECALL = 3'd4
  } nvs_state_e;

  // largest of three durations, used to size the shared counter
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return m;
  endfunction

  // counter load value for a state that lasts n cycles
  function automatic int unsigned span_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvs_dirty.sv
module nvs_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty <= 1'b0;
    end else if (set_i) begin
      dirty <= 1'b1;
    end else if (clr_i) begin
      dirty <= 1'b0;
    end
  end
endmodule

// File: rtl/nvs_rcl_req.sv
module nvs_rcl_req (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_low,
  input  logic arm_i,
  input  logic done_i,
  output logic pend
);
  // reset counts as a power-up, so a recall is owed
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b1;
    end else if (deep_low || arm_i) begin
      pend <= 1'b1;
    end else if (done_i) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/nvshadow_seq.sv
module nvshadow_seq #(
  parameter int unsigned GRACE_CYC  = 200,
  parameter int unsigned STORE_CYC  = 2000000,
  parameter int unsigned RECALL_CYC = 110000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_ok,
  input  logic sup_dead,
  input  logic host_wr,
  input  logic sw_recall,
  output logic wr_inhibit,
  output logic busy,
  output logic store_go,
  output logic recall_go
);
  import nvs_pkg::*;

  localparam int unsigned MAXD = max3(GRACE_CYC, STORE_CYC, RECALL_CYC);
  localparam int          CW   = $clog2(MAXD + 1) + 1;
  localparam logic [CW-1:0] LD_GRACE  = CW'(span_load(GRACE_CYC));
  localparam logic [CW-1:0] LD_STORE  = CW'(span_load(STORE_CYC));
  localparam logic [CW-1:0] LD_RECALL = CW'(span_load(RECALL_CYC));

  nvs_state_e state_q, state_d;
  logic [CW-1:0] load_val;
  logic          tmr_load;
  logic          tmr_exp;
  logic          dirty_w;
  logic          pend_w;
  logic          supply_good;

  // named internal events, also used by the checker
  logic wr_take_w;
  logic st_done_w;
  logic rcl_done_w;
  logic sw_arm_w;
  logic in_recall;
  logic store_go_q, recall_go_q;

  assign supply_good = sup_ok && !sup_dead;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!supply_good) state_d = dirty_w ? ST_GRACE : ST_DOWN;
        else if (sw_recall) state_d = ST_RECALL;
      end
      ST_GRACE: begin
        if (tmr_exp) state_d = ST_STORE;
      end
      ST_STORE: begin
        if (tmr_exp) state_d = ST_DOWN;
      end
      ST_DOWN: begin
        if (supply_good) state_d = pend_w ? ST_RECALL : ST_IDLE;
      end
      ST_RECALL: begin
        if (!supply_good) state_d = ST_DOWN;
        else if (tmr_exp) state_d = ST_IDLE;
      end
      default: state_d = ST_DOWN;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_GRACE:  load_val = LD_GRACE;
      ST_STORE:  load_val = LD_STORE;
      ST_RECALL: load_val = LD_RECALL;
      default:   load_val = '0;
    endcase
  end

  assign tmr_load   = (state_d != state_q);
  assign in_recall  = (state_q == ST_RECALL);
  assign busy       = (state_q == ST_STORE) || in_recall;
  assign wr_inhibit = !((state_q == ST_IDLE) && supply_good);
  assign wr_take_w  = host_wr && !wr_inhibit;
  assign st_done_w  = (state_q == ST_STORE) && tmr_exp;
  assign rcl_done_w = in_recall && (state_d == ST_IDLE);
  assign sw_arm_w   = (state_q == ST_IDLE) && (state_d == ST_RECALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_DOWN;
      store_go_q  <= 1'b0;
      recall_go_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      store_go_q  <= (state_d == ST_STORE)  && (state_q != ST_STORE);
      recall_go_q <= (state_d == ST_RECALL) && (state_q != ST_RECALL);
    end
  end

  assign store_go  = store_go_q;
  assign recall_go = recall_go_q;

  nvs_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(load_val), .expired(tmr_exp)
  );

  nvs_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .set_i(wr_take_w),
    .clr_i(st_done_w || rcl_done_w), .dirty(dirty_w)
  );

  nvs_rcl_req u_req (
    .clk(clk), .rst_n(rst_n), .deep_low(sup_dead), .arm_i(sw_arm_w),
    .done_i(rcl_done_w), .pend(pend_w)
  );
endmodule

// File: rtl/nvshadow_seq_chk.sv
module nvshadow_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_ok,
  input logic sup_dead,
  input logic wr_inhibit,
  input logic busy,
  input logic store_go,
  input logic recall_go,
  input logic dirty_w,
  input logic wr_take_w,
  input logic rcl_done_w,
  input logic in_recall
);
  // R2
  inhibit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wr_inhibit);
  // R2
  inhibit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |-> wr_inhibit);
  // R2
  take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take_w |-> !busy);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_go && recall_go));
  // R3
  store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> dirty_w);
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (store_go || recall_go));
  // R7
  recall_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_go |-> $past(sup_ok));
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_recall && sup_dead) |=> !busy);
  // R8
  clean_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_done_w |=> !dirty_w);
endmodule

bind nvshadow_seq nvshadow_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .sup_dead(sup_dead),
  .wr_inhibit(wr_inhibit), .busy(busy), .store_go(store_go), .recall_go(recall_go),
  .dirty_w(dirty_w), .wr_take_w(wr_take_w), .rcl_done_w(rcl_done_w), .in_recall(in_recall)
);

// File: tb/sim_nvshadow_seq.sv
`timescale 1ns/1ps
module sim_nvshadow_seq;
  localparam int G = 4;
  localparam int S = 20;
  localparam int R = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_ok = 1'b0, sup_dead = 1'b0, host_wr = 1'b0, sw_recall = 1'b0;
  logic wr_inhibit, busy, store_go, recall_go;

  always #2.5 clk = ~clk;

  nvshadow_seq #(.GRACE_CYC(G), .STORE_CYC(S), .RECALL_CYC(R)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .sup_dead(sup_dead),
    .host_wr(host_wr), .sw_recall(sw_recall), .wr_inhibit(wr_inhibit),
    .busy(busy), .store_go(store_go), .recall_go(recall_go)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  int n_store = 0, n_recall = 0;
  int store_cyc = -1, recall_cyc = -1;
  int run_len = 0, last_len = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (store_go)  begin n_store++;  store_cyc = cyc;  end
      if (recall_go) begin n_recall++; recall_cyc = cyc; end
      if (busy) run_len++;
      else if (run_len != 0) begin last_len = run_len; run_len = 0; end
    end
  end

  function automatic int store_lat(input int grace);  return grace + 1; endfunction
  function automatic int recall_lat();                return 1;         endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_once();
    host_wr = 1'b1; step(1); host_wr = 1'b0;
  endtask

  task automatic power_rise(input bit expect_rcl, input string req);
    int k, r0;
    r0 = n_recall; k = cyc;
    sup_dead = 1'b0; sup_ok = 1'b1;
    step(R + 4);
    chk((n_recall - r0) == (expect_rcl ? 1 : 0), req, n_recall - r0, expect_rcl ? 1 : 0);
    if (expect_rcl) begin
      chk(recall_cyc == k + recall_lat(), req, recall_cyc - k, recall_lat());
      chk(last_len == R, req, last_len, R);
    end
  endtask

  task automatic power_drop(input bit expect_st, input bit deep, input string req);
    int k, s0;
    s0 = n_store; k = cyc;
    sup_ok = 1'b0;
    step(2);
    if (deep) sup_dead = 1'b1;
    step(G + S + 4);
    sup_dead = 1'b0;
    step(2);
    chk((n_store - s0) == (expect_st ? 1 : 0), req, n_store - s0, expect_st ? 1 : 0);
    if (expect_st) begin
      chk(store_cyc == k + store_lat(G), req, store_cyc - k, store_lat(G));
      chk(last_len == S, req, last_len, S);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit dirty_m, pend_m;
    step(3);
    #0;
    // R1 reset values
    chk(busy == 0 && store_go == 0 && recall_go == 0, "R1", busy, 0);
    chk(wr_inhibit == 1, "R1", wr_inhibit, 1);
    rst_n = 1'b1;
    step(5);
    chk(n_recall == 0, "R1", n_recall, 0);
    // R1 / R7 power-up recall
    power_rise(1'b1, "R1");
    // R2 writes allowed when idle and good
    chk(wr_inhibit == 0, "R2", wr_inhibit, 0);

    // R4 clean drop, R6 shallow brownout: no store, no recall
    power_drop(1'b0, 1'b0, "R4");
    chk(wr_inhibit == 1, "R2", wr_inhibit, 1);
    write_once();                       // ignored, supply low (R2)
    power_rise(1'b0, "R6");
    power_drop(1'b0, 1'b0, "R2");       // rejected write left array clean
    power_rise(1'b0, "R6");

    // R3 / R5 dirty drop, shallow: store, no recall
    write_once();
    power_drop(1'b1, 1'b0, "R3");
    power_rise(1'b0, "R6");
    // R8 store cleaned the array
    power_drop(1'b0, 1'b0, "R8");
    power_rise(1'b0, "R8");

    // R7 deep brownout with store, recall on return
    write_once();
    power_drop(1'b1, 1'b1, "R5");
    power_rise(1'b1, "R7");

    // R8 write then software recall, then drop: no store
    write_once();
    sw_recall = 1'b1; step(1); sw_recall = 1'b0;
    step(R + 3);
    chk(last_len == R, "R9", last_len, R);
    power_drop(1'b0, 1'b0, "R8");

    // R9 software recall ignored while supply low
    begin
      int r0;
      r0 = n_recall;
      sw_recall = 1'b1; step(3); sw_recall = 1'b0;
      chk(n_recall == r0, "R9", n_recall - r0, 0);
    end
    power_rise(1'b0, "R9");

    // R9 ignored while busy; R2 writes during busy ignored
    begin
      int r0;
      r0 = n_recall;
      sw_recall = 1'b1; step(1); sw_recall = 1'b0;
      step(2);
      chk(busy == 1 && wr_inhibit == 1, "R2", wr_inhibit, 1);
      sw_recall = 1'b1; host_wr = 1'b1; step(4); sw_recall = 1'b0; host_wr = 1'b0;
      step(R + 3);
      chk(n_recall - r0 == 1, "R9", n_recall - r0, 1);
    end
    power_drop(1'b0, 1'b0, "R2");

    // R10 abort mid-recall and restart
    sup_dead = 1'b1; step(3); sup_dead = 1'b0;
    sup_ok = 1'b1; step(4);
    chk(busy == 1, "R10", busy, 1);
    sup_ok = 1'b0; sup_dead = 1'b1; step(1);
    @(negedge clk);
    chk(busy == 0, "R10", busy, 0);
    step(3); sup_dead = 1'b0; step(2);
    power_rise(1'b1, "R10");

    // random rounds against a bench model
    void'($urandom(32'h5eed_0042));
    dirty_m = 1'b0;
    for (int i = 0; i < 20; i++) begin
      bit wr, deep;
      wr = $urandom_range(0, 1);
      deep = $urandom_range(0, 1);
      if (wr) write_once();
      step($urandom_range(0, 5));
      dirty_m = dirty_m | wr;
      power_drop(dirty_m, deep, "R3");
      dirty_m = 1'b0;
      pend_m = deep;
      power_rise(pend_m, "R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule